// File: doc/BRIEF.md
# Receive-Side Idle Alignment Controller

This block sits behind the character decoder of one serial receive link and decides, word by word, what reaches the link's input buffer. Each decoded 32-bit word is classified as payload or as the link's filler pattern. Filler is never stored. The block produces a registered write strobe, address and data for an external buffer RAM. A long unbroken stretch of filler is an in-band command from the transmitter. It returns the write address and the frame position to zero, so that every link in a multi-link receiver starts storing at the same location even though each transmitter runs from its own oscillator.

Payload arrives in frames of seven words. The last word of each frame carries a clock counter and a revolution counter. The block compares every footer with the one before it and raises a sticky flag when the counters do not advance as expected. A decoder error, such as lost lock or a disparity fault, stops all writes until the next in-band realignment.

Top module: `rx_idle_align`

## Requirements
- R1: A word is filler when `rx_word` is 32'hBCC5BC50 and `rx_kflag` is 4'b1010 (bit 3 flags the most significant byte as a control character). Filler is never written. A word with the same value but other `rx_kflag` bits, or with any other value, is payload and is written.
- R2: Each payload word is written once, two clock edges after it is presented. Successive writes use consecutive addresses that wrap modulo 2^ADDR_W, and `wr_data` equals the word.
- R3: A run of one, two or three consecutive filler words causes no realignment, and the address sequence continues across it.
- R4: The fourth consecutive filler word raises `realign` for exactly one cycle. The next payload word is then written at address 0. A longer run still produces only one pulse. Cycles with `rx_valid` low neither extend nor break a run.
- R5: `word_pos` gives the position of each written word within its frame. It counts 0 to 6, returns to 0 after 6, and restarts at 0 after a realignment.
- R6: The word at position 6 is the footer, with the clock counter in bits [8:0] and the revolution counter in bits [22:16]. The first footer after reset or realignment only sets the reference. Every later footer must show a clock counter equal to the previous footer's value plus 3, modulo 512. Otherwise `sync_err` is set.
- R7: A footer whose revolution counter is neither equal to the previous footer's value nor one more than it, modulo 128, sets `sync_err`.
- R8: `sync_err` stays set until the next realignment clears it. Each footer is always compared with the footer immediately before it, including a footer that was itself flagged.
- R9: A cycle with `rx_err` high sets `link_err`. The word in that cycle is not written and it breaks any filler run. While `link_err` is high no payload is written. Only a realignment clears `link_err`.
- R10: After reset, `wr_en`, `realign`, `link_err` and `sync_err` are low. The first payload word goes to address 0 at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A decoded word is present this cycle |
| rx_word | input | 32 | Decoded word |
| rx_kflag | input | 4 | Control-character flag per byte, bit 3 for bits [31:24] |
| rx_err | input | 1 | Decoder loss-of-lock or disparity error |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | 32 | Buffer write data |
| word_pos | output | 3 | Frame position of the word being written |
| realign | output | 1 | One-cycle pulse on an in-band realignment |
| link_err | output | 1 | Decoder error seen since the last realignment |
| sync_err | output | 1 | Sticky footer counter mismatch |

## Verification
The bench builds the block with ADDR_W set to 4, so the write address wraps after sixteen stored words. This makes the modulo addressing of R2 reachable within a short stream. Frame length, run threshold, counter widths and the counter step stay at their defaults. Those defaults let the bench use footer values that cross the 512 and 128 counter boundaries and filler runs of every length from one to five.

// File: rtl/rxalign_pkg.sv
`timescale 1ns/1ps
package rxalign_pkg;
  localparam logic [31:0] FILL_WORD  = 32'hBCC5_BC50;
  localparam logic [3:0]  FILL_KMASK = 4'b1010;

  typedef struct packed {
    logic        valid;
    logic        fill;
    logic        err;
    logic [31:0] word;
  } rx_class_t;
endpackage

// File: rtl/rxalign_classify.sv
`timescale 1ns/1ps
module rxalign_classify
  import rxalign_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [31:0] rx_word,
  input  logic [3:0]  rx_kflag,
  input  logic        rx_err,
  output rx_class_t   cls
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cls <= '0;
    end else begin
      cls.valid <= rx_valid;
      cls.fill  <= rx_valid && !rx_err && (rx_word == FILL_WORD) && (rx_kflag == FILL_KMASK);
      cls.err   <= rx_err;
      cls.word  <= rx_word;
    end
  end
endmodule

// File: rtl/rxalign_runlen.sv
`timescale 1ns/1ps
module rxalign_runlen #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_fill,
  input  logic in_err,
  output logic realign_now,
  output logic realign_q
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] run_q;

  always_comb realign_now = in_valid && in_fill && (run_q == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      realign_q <= 1'b0;
    end else begin
      realign_q <= realign_now;
      if (in_err) begin
        run_q <= '0;
      end else if (in_valid) begin
        if (!in_fill)
          run_q <= '0;
        else if (run_q != RUN_W'(RUN_LEN))
          run_q <= run_q + 1'b1;
      end
    end
  end

  // R4: a run yields one pulse only
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    realign_now |=> !realign_now);
endmodule

// File: rtl/rxalign_wrctl.sv
`timescale 1ns/1ps
module rxalign_wrctl
  import rxalign_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int FRAME_LEN = 7,
  parameter int POS_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  rx_class_t         cls,
  input  logic              realign_now,
  output logic              footer_now,
  output logic              wr_en_q,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [31:0]       wr_data_q,
  output logic [POS_W-1:0]  wr_pos_q,
  output logic              link_err_q
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [ADDR_W-1:0] ptr_q;
  logic [POS_W-1:0]  pos_q;
  logic              write_now;

  always_comb begin
    write_now  = cls.valid && !cls.fill && !cls.err && !link_err_q;
    footer_now = write_now && (pos_q == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      pos_q      <= '0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      wr_pos_q   <= '0;
      link_err_q <= 1'b0;
    end else begin
      wr_en_q <= write_now;
      if (write_now) begin
        wr_addr_q <= ptr_q;
        wr_data_q <= cls.word;
        wr_pos_q  <= pos_q;
        ptr_q     <= ptr_q + 1'b1;
        pos_q     <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      end
      if (realign_now) begin
        ptr_q <= '0;
        pos_q <= '0;
      end
      if (cls.err)
        link_err_q <= 1'b1;
      else if (realign_now)
        link_err_q <= 1'b0;
    end
  end

  a_r1_fill_not_written: assert property (@(posedge clk) disable iff (rst)
    (cls.valid && cls.fill) |=> !wr_en_q);
  a_r9_err_blocks_write: assert property (@(posedge clk) disable iff (rst)
    link_err_q |-> !wr_en_q);
  a_r4_realign_restarts: assert property (@(posedge clk) disable iff (rst)
    realign_now |=> (ptr_q == '0 && pos_q == '0));
  a_r5_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> (wr_pos_q <= LAST_POS));
endmodule

// File: rtl/rxalign_footer.sv
`timescale 1ns/1ps
module rxalign_footer #(
  parameter int CLK_W    = 9,
  parameter int REV_W    = 7,
  parameter int CLK_STEP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             footer_now,
  input  logic             realign_now,
  input  logic [CLK_W-1:0] clk_field,
  input  logic [REV_W-1:0] rev_field,
  output logic             sync_err_q
);
  logic             seen_q;
  logic [CLK_W-1:0] clk_prev_q;
  logic [REV_W-1:0] rev_prev_q;
  logic [CLK_W-1:0] clk_next;
  logic [REV_W-1:0] rev_next;
  logic             mismatch;

  always_comb begin
    clk_next = clk_prev_q + CLK_W'(CLK_STEP);
    rev_next = rev_prev_q + 1'b1;
    mismatch = seen_q && ((clk_field != clk_next) ||
                          ((rev_field != rev_prev_q) && (rev_field != rev_next)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      clk_prev_q <= '0;
      rev_prev_q <= '0;
      sync_err_q <= 1'b0;
    end else if (realign_now) begin
      seen_q     <= 1'b0;
      sync_err_q <= 1'b0;
    end else if (footer_now) begin
      seen_q     <= 1'b1;
      clk_prev_q <= clk_field;
      rev_prev_q <= rev_field;
      if (mismatch)
        sync_err_q <= 1'b1;
    end
  end

  a_r8_sync_sticky: assert property (@(posedge clk) disable iff (rst)
    (sync_err_q && !realign_now) |=> sync_err_q);
  a_r6_first_footer_loads: assert property (@(posedge clk) disable iff (rst)
    (footer_now && !seen_q && !sync_err_q) |=> !sync_err_q);
endmodule

// File: rtl/rx_idle_align.sv
`timescale 1ns/1ps
module rx_idle_align
  import rxalign_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int FRAME_LEN = 7,
  parameter int RUN_LEN   = 4,
  parameter int CLK_W     = 9,
  parameter int CLK_LSB   = 0,
  parameter int REV_W     = 7,
  parameter int REV_LSB   = 16,
  parameter int CLK_STEP  = 3,
  parameter int POS_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [31:0]       rx_word,
  input  logic [3:0]        rx_kflag,
  input  logic              rx_err,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [POS_W-1:0]  word_pos,
  output logic              realign,
  output logic              link_err,
  output logic              sync_err
);
  rx_class_t cls;
  logic      realign_now;
  logic      footer_now;

  rxalign_classify u_cls (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
    .rx_kflag(rx_kflag), .rx_err(rx_err), .cls(cls)
  );

  rxalign_runlen #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .in_valid(cls.valid), .in_fill(cls.fill),
    .in_err(cls.err), .realign_now(realign_now), .realign_q(realign)
  );

  rxalign_wrctl #(.ADDR_W(ADDR_W), .FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_wr (
    .clk(clk), .rst(rst), .cls(cls), .realign_now(realign_now),
    .footer_now(footer_now), .wr_en_q(wr_en), .wr_addr_q(wr_addr),
    .wr_data_q(wr_data), .wr_pos_q(word_pos), .link_err_q(link_err)
  );

  rxalign_footer #(.CLK_W(CLK_W), .REV_W(REV_W), .CLK_STEP(CLK_STEP)) u_ftr (
    .clk(clk), .rst(rst), .footer_now(footer_now), .realign_now(realign_now),
    .clk_field(cls.word[CLK_LSB +: CLK_W]), .rev_field(cls.word[REV_LSB +: REV_W]),
    .sync_err_q(sync_err)
  );
endmodule

// File: tb/sim_rx_idle_align.sv
`timescale 1ns/1ps
module sim_rx_idle_align;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [31:0]   rx_word = '0;
  logic [3:0]    rx_kflag = '0;
  logic          rx_err = 1'b0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [2:0]    word_pos;
  logic          realign;
  logic          link_err;
  logic          sync_err;

  rx_idle_align #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
    .rx_kflag(rx_kflag), .rx_err(rx_err), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .word_pos(word_pos), .realign(realign),
    .link_err(link_err), .sync_err(sync_err)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [2:0]    p;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   act_pulses = 0;
  int   exp_pulses = 0;
  int   seq = 0;
  bit   done = 1'b0;

  // requirement model
  logic [AW-1:0] m_ptr = '0;
  logic [2:0]    m_pos = '0;
  int            m_run = 0;
  bit            m_lerr = 1'b0;
  bit            m_seen = 1'b0;
  bit            m_sync = 1'b0;
  logic [8:0]    m_clk = '0;
  logic [6:0]    m_rev = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [3:0] k, input bit v, input bit e);
    logic [6:0] r;
    logic [8:0] c;
    @(negedge clk);
    rx_valid = v; rx_word = w; rx_kflag = k; rx_err = e;
    if (e) begin
      m_lerr = 1'b1;
      m_run  = 0;
    end else if (v) begin
      if (w == 32'hBCC5_BC50 && k == 4'b1010) begin
        if (m_run == 3) begin
          exp_pulses++;
          m_ptr = '0; m_pos = '0; m_lerr = 1'b0; m_seen = 1'b0; m_sync = 1'b0;
        end
        if (m_run < 4) m_run++;
      end else begin
        m_run = 0;
        if (!m_lerr) begin
          q.push_back('{a: m_ptr, d: w, p: m_pos});
          if (m_pos == 3'd6) begin
            c = w[8:0];
            r = w[22:16];
            if (m_seen && ((c != m_clk + 9'd3) || (r != m_rev && r != m_rev + 7'd1)))
              m_sync = 1'b1;
            m_seen = 1'b1; m_clk = c; m_rev = r;
          end
          m_ptr = m_ptr + 1'b1;
          m_pos = (m_pos == 3'd6) ? 3'd0 : m_pos + 3'd1;
        end
      end
    end
  endtask

  task automatic data_w();
    seq++;
    drive(32'h1000_0000 + seq, 4'b0000, 1'b1, 1'b0);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) drive(32'hBCC5_BC50, 4'b1010, 1'b1, 1'b0);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) drive(32'h0, 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic frame(input logic [6:0] r, input logic [8:0] c);
    for (int i = 0; i < 6; i++) data_w();
    drive({9'd0, r, 7'd0, c}, 4'b0000, 1'b1, 1'b0);
  endtask

  task automatic settle(input string req);
    gap(3);
    chk(link_err == m_lerr, {req, " link_err"}, link_err, m_lerr);
    chk(sync_err == m_sync, {req, " sync_err"}, sync_err, m_sync);
    chk(act_pulses == exp_pulses, {req, " realign count"}, act_pulses, exp_pulses);
    chk(q.size() == 0, {req, " pending writes"}, q.size(), 0);
  endtask

  // monitor: pop and compare each write (R2 address/data, R5 position)
  always @(negedge clk) begin
    if (!rst) begin
      if (realign) act_pulses++;
      if (wr_en) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected write", wr_data, 0);
        end else begin
          exp_t x;
          x = q.pop_front();
          chk(wr_addr == x.a, "R2 address", wr_addr, x.a);
          chk(wr_data == x.d, "R2 data", wr_data, x.d);
          chk(word_pos == x.p, "R5 position", word_pos, x.p);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!wr_en && !realign && !link_err && !sync_err, "R10 reset outputs",
        {wr_en, realign, link_err, sync_err}, 0);

    // R3 short filler runs inside a frame, gaps do not matter
    data_w(); data_w(); fill(1); data_w(); gap(2); data_w(); fill(2); data_w();
    fill(3); data_w();
    drive({9'd0, 7'd5, 7'd0, 9'd10}, 4'b0000, 1'b1, 1'b0);
    settle("R3");
    // R6 / R7 good footers
    frame(7'd5, 9'd13);
    frame(7'd6, 9'd16);
    settle("R6");

    // R4 realignment via a five-long run split by an invalid cycle
    fill(2); gap(1); fill(3);
    frame(7'd9, 9'd100);
    frame(7'd9, 9'd103);
    settle("R4");

    // R6 wrong step, R8 sticky and chained comparison
    frame(7'd9, 9'd107);
    settle("R6 bad step");
    frame(7'd9, 9'd110);
    settle("R8 sticky");
    fill(4);
    settle("R8 cleared");

    // R7 revolution jump by two
    frame(7'd2, 9'd0);
    frame(7'd4, 9'd3);
    settle("R7 jump");
    // R6 / R7 counter wrap
    fill(4);
    frame(7'd127, 9'd510);
    frame(7'd0, 9'd1);
    settle("R7 wrap");

    // R1 near-filler words are payload
    drive(32'hBCC5_BC50, 4'b0000, 1'b1, 1'b0);
    drive(32'hBCC5_BC51, 4'b1010, 1'b1, 1'b0);
    drive(32'hBCC5_BC50, 4'b1000, 1'b1, 1'b0);
    fill(1);
    settle("R1");

    // R9 decoder error blocks writes until realignment
    fill(4);
    data_w();
    drive(32'h2222_2222, 4'b0000, 1'b1, 1'b1);
    data_w(); data_w(); fill(3);
    settle("R9 blocked");
    fill(2); drive(32'hBCC5_BC50, 4'b1010, 1'b1, 1'b1); fill(2);
    settle("R9 run broken");
    fill(4);
    data_w(); data_w();
    settle("R9 resumed");

    // R2 address wrap over sixteen locations
    for (int i = 0; i < 20; i++) data_w();
    settle("R2 wrap");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule